// File: doc/BRIEF.md
# T1 Facility Data Link Byte Port

This block moves the T1 facility data link between a framer's bit-level timing and a host that works in whole bytes. On the receive side the framer hands over one recovered link bit per single-cycle strobe. In extended-superframe mode these are the data link bits. In superframe (D4) mode they are the Fs bits, and a separate strobe marks each multiframe boundary. The bits are collected least significant bit first. The finished byte goes into a readable register, and a latched full flag is raised. When the full flag is enabled in the mask register, it drives an active-low interrupt.

The bits are passed on exactly as recovered, with no zero destuffing. The host has one byte time to read a byte before the next one replaces it. If a byte completes while the previous one is still flagged, an overrun flag records it. On the transmit side the host writes a byte. A serializer presents one bit per framer slot strobe, least significant bit first. It sends eight bits per byte in extended-superframe mode and six in D4 mode. It picks up the host byte after its last bit and repeats the old byte if nothing new was written.

The host reaches four registers through a plain write-enable and address port with a combinational read.

Top module: `fdl_byte_port`

## Requirements
- R1: After reset, every register reads 0x00, `irq_n` is 1 and `tx_bit` is 0.
- R2: In extended-superframe mode (`mode_d4`=0), the first received bit lands in bit 0. Once the eighth `rx_bit_stb` has been sampled, the assembled byte reads from address 0 in the next cycle.
- R3: A completed byte sets the full flag, which is status register (address 2) bit 2. The address-0 value changes only when a byte completes.
- R4: `irq_n` is 0 exactly while the full flag is set and bit 2 of the mask register (address 3) is 1.
- R5: Writing address 2 with bit 2 set clears the full flag. Writing 0 to that bit has no effect. A byte that completes in the same cycle as the clear leaves the flag set.
- R6: A byte that completes while the full flag is still set also sets the overrun flag (address 2 bit 3). Writing 1 to bit 3 clears the overrun flag.
- R7: A newly completed byte replaces an unread one. All bit patterns, including long runs of ones, are kept unchanged.
- R8: In D4 mode, received bits are only transferred to address 0 when `rx_mf_stb` is sampled. A bit strobed in that same cycle is included, and bits 6 and 7 read as 0. In extended-superframe mode `rx_mf_stb` is ignored.
- R9: In extended-superframe mode, `tx_bit` shows the current bit of the byte being sent, starting at bit 0. Each `tx_slot_stb` advances it by one bit. After bit 7, the serializer loads the byte held at address 1.
- R10: In D4 mode, the serializer sends bits 0 to 5 only and reloads after bit 5.
- R11: If address 1 has not been rewritten, the same byte is sent again.
- R12: Writes to address 0 are ignored. Address 1 reads back as written. The mask register keeps only bit 2, and all other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_d4 | input | 1 | 1 = D4 (Fs bits, six-bit transmit), 0 = extended superframe |
| rx_bit_stb | input | 1 | Single-cycle strobe: `rx_bit` holds a recovered link bit |
| rx_bit | input | 1 | Recovered link or Fs bit |
| rx_mf_stb | input | 1 | Single-cycle multiframe boundary strobe (D4 only) |
| tx_slot_stb | input | 1 | Single-cycle strobe: the framer consumes `tx_bit` |
| tx_bit | output | 1 | Link bit for the current transmit slot |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 2 | Register address: 0 receive, 1 transmit, 2 status, 3 mask |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The bench builds the block with its default byte width of 8 and D4 width of 6. These sizes let it run every one of the 256 receive bytes and 256 transmit bytes in extended-superframe mode, and all 64 six-bit values in D4 mode. It computes each expected bit by shifting the loop value. It also places multiframe strobes in extended-superframe mode and extra upper bits in D4 mode, to confirm that each is ignored or masked. Single directed sequences cover the flag corners: clear in the same cycle as a completing byte, overrun, write-zero, and interrupt masking.

// File: rtl/fdl_pkg.sv
// Package: shared register map and flag positions for the link byte port.
// Assumes a two-bit host address space.
package fdl_pkg;
    localparam int REG_ADDR_W = 2;

    typedef enum logic [REG_ADDR_W-1:0] {
        REG_RXBYTE = 2'd0,
        REG_TXBYTE = 2'd1,
        REG_STATUS = 2'd2,
        REG_MASK   = 2'd3
    } reg_sel_e;

    // Flags occupy consecutive status bits from FLAG_BASE: full, then overrun.
    localparam int FLAG_BASE  = 2;
    localparam int NUM_FLAGS  = 2;
    localparam int FLAG_FULL  = 0;
    localparam int FLAG_OVR   = 1;
    localparam int MASK_BIT   = 2;
endpackage

// File: rtl/fdl_rx_assembler.sv
// Module: collects single-cycle link bit strobes, LSB first, into a byte.
// ESF: completes on the DATA_W-th bit. D4: completes on the multiframe
// strobe, with a same-cycle bit included and bits above D4_BITS cleared.
// Assumes strobes are synchronous to clk. No destuffing is applied.
module fdl_rx_assembler #(
    parameter int DATA_W  = 8,
    parameter int D4_BITS = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_d4,
    input  logic              bit_stb,
    input  logic              bit_in,
    input  logic              mf_stb,
    output logic              byte_done,
    output logic [DATA_W-1:0] byte_out
);
    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam int IDX_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0]  FULL_CNT = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0]  LAST_CNT = CNT_W'(DATA_W - 1);
    localparam logic [DATA_W-1:0] D4_MASK  = DATA_W'((1 << D4_BITS) - 1);

    logic [DATA_W-1:0] acc_q, acc_ins;
    logic [CNT_W-1:0]  cnt_q, cnt_ins;
    logic              room;

    // Place the strobed bit at the next free position.
    always_comb begin
        acc_ins = acc_q;
        cnt_ins = cnt_q;
        room    = (cnt_q < FULL_CNT);
        if (bit_stb && room) begin
            acc_ins[cnt_q[IDX_W-1:0]] = bit_in;
            cnt_ins = cnt_q + 1'b1;
        end
    end

    // Decide completion per mode and trim unused D4 bits.
    always_comb begin
        if (mode_d4) begin
            byte_done = mf_stb;
            byte_out  = acc_ins & D4_MASK;
        end else begin
            byte_done = bit_stb && (cnt_q == LAST_CNT);
            byte_out  = acc_ins;
        end
    end

    // Hold the partial byte; start afresh after each completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            cnt_q <= '0;
        end else if (byte_done) begin
            acc_q <= '0;
            cnt_q <= '0;
        end else begin
            acc_q <= acc_ins;
            cnt_q <= cnt_ins;
        end
    end
endmodule

// File: rtl/fdl_tx_serializer.sv
// Module: presents one bit of a shadow byte per slot, LSB first, and
// reloads the shadow from the host byte after the last valid bit
// (DATA_W-1 in ESF, D4_BITS-1 in D4). Assumes slot strobes last one cycle.
module fdl_tx_serializer #(
    parameter int DATA_W  = 8,
    parameter int D4_BITS = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_d4,
    input  logic              slot_stb,
    input  logic [DATA_W-1:0] host_byte,
    output logic              tx_bit
);
    localparam int IDX_W = $clog2(DATA_W);
    localparam logic [IDX_W-1:0] ESF_LAST = IDX_W'(DATA_W - 1);
    localparam logic [IDX_W-1:0] D4_LAST  = IDX_W'(D4_BITS - 1);

    logic [DATA_W-1:0] shadow_q;
    logic [IDX_W-1:0]  idx_q;
    logic [IDX_W-1:0]  last_idx;

    // Last bit position depends on framing mode.
    always_comb last_idx = mode_d4 ? D4_LAST : ESF_LAST;

    // Current slot bit.
    always_comb tx_bit = shadow_q[idx_q];

    // Advance on each slot; wrap and reload after the last bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= '0;
            idx_q    <= '0;
        end else if (slot_stb) begin
            if (idx_q >= last_idx) begin
                idx_q    <= '0;
                shadow_q <= host_byte;
            end else begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/fdl_host_regs.sv
// Module: host-visible registers: receive byte, transmit byte, latched
// write-one-to-clear flags (full, overrun) and the interrupt mask.
// Setting a flag wins over clearing it in the same cycle.
module fdl_host_regs
    import fdl_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [REG_ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0]     wdata,
    output logic [DATA_W-1:0]     rdata,
    input  logic                  rx_done,
    input  logic [DATA_W-1:0]     rx_byte,
    output logic [DATA_W-1:0]     rx_data,
    output logic [DATA_W-1:0]     tx_byte,
    output logic                  full,
    output logic                  ovr,
    output logic                  mask_en,
    output logic                  irq_n
);
    logic [NUM_FLAGS-1:0] flag_q, flag_set, flag_clr;
    logic                 wr_stat;
    reg_sel_e             sel;

    always_comb sel     = reg_sel_e'(addr);
    always_comb wr_stat = wr_en && (sel == REG_STATUS);

    // Set sources: completion sets full; completion on a full register sets overrun.
    always_comb begin
        flag_set            = '0;
        flag_set[FLAG_FULL] = rx_done;
        flag_set[FLAG_OVR]  = rx_done && flag_q[FLAG_FULL];
    end

    genvar g;
    generate
        for (g = 0; g < NUM_FLAGS; g++) begin : g_flag
            // Clear request from the matching status bit.
            assign flag_clr[g] = wr_stat && wdata[FLAG_BASE + g];

            // Latched flag, set priority over clear.
            always_ff @(posedge clk) begin
                if (!rst_n)            flag_q[g] <= 1'b0;
                else if (flag_set[g])  flag_q[g] <= 1'b1;
                else if (flag_clr[g])  flag_q[g] <= 1'b0;
            end
        end
    endgenerate

    // Receive byte loads only on completion.
    always_ff @(posedge clk) begin
        if (!rst_n)       rx_data <= '0;
        else if (rx_done) rx_data <= rx_byte;
    end

    // Host-written transmit byte and mask bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_byte <= '0;
            mask_en <= 1'b0;
        end else if (wr_en) begin
            if (sel == REG_TXBYTE) tx_byte <= wdata;
            if (sel == REG_MASK)   mask_en <= wdata[MASK_BIT];
        end
    end

    // Combinational read mux.
    always_comb begin
        rdata = '0;
        case (sel)
            REG_RXBYTE: rdata = rx_data;
            REG_TXBYTE: rdata = tx_byte;
            REG_STATUS: rdata[FLAG_BASE +: NUM_FLAGS] = flag_q;
            REG_MASK:   rdata[MASK_BIT] = mask_en;
            default:    rdata = '0;
        endcase
    end

    always_comb full  = flag_q[FLAG_FULL];
    always_comb ovr   = flag_q[FLAG_OVR];
    // Interrupt output, active low.
    always_comb irq_n = ~(flag_q[FLAG_FULL] & mask_en);
endmodule

// File: rtl/fdl_byte_port.sv
// Module: top of the T1 link byte port. Joins the receive assembler,
// transmit serializer and host registers. Assumes all strobes are
// single-cycle and synchronous to clk.
module fdl_byte_port
    import fdl_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int D4_BITS = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  mode_d4,
    input  logic                  rx_bit_stb,
    input  logic                  rx_bit,
    input  logic                  rx_mf_stb,
    input  logic                  tx_slot_stb,
    output logic                  tx_bit,
    input  logic                  reg_wr,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0]     reg_wdata,
    output logic [DATA_W-1:0]     reg_rdata,
    output logic                  irq_n
);
    logic              rx_done;
    logic [DATA_W-1:0] rx_byte;
    logic [DATA_W-1:0] rx_data;
    logic [DATA_W-1:0] tx_byte;
    logic              full, ovr, mask_en;

    fdl_rx_assembler #(.DATA_W(DATA_W), .D4_BITS(D4_BITS)) u_rx (
        .clk(clk), .rst_n(rst_n), .mode_d4(mode_d4),
        .bit_stb(rx_bit_stb), .bit_in(rx_bit), .mf_stb(rx_mf_stb),
        .byte_done(rx_done), .byte_out(rx_byte)
    );

    fdl_tx_serializer #(.DATA_W(DATA_W), .D4_BITS(D4_BITS)) u_tx (
        .clk(clk), .rst_n(rst_n), .mode_d4(mode_d4),
        .slot_stb(tx_slot_stb), .host_byte(tx_byte), .tx_bit(tx_bit)
    );

    fdl_host_regs #(.DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata),
        .rx_done(rx_done), .rx_byte(rx_byte), .rx_data(rx_data),
        .tx_byte(tx_byte), .full(full), .ovr(ovr), .mask_en(mask_en),
        .irq_n(irq_n)
    );
endmodule

// File: rtl/fdl_port_checker.sv
// Module: temporal checks on the link byte port, bound to the top.
module fdl_port_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_done,
    input logic              full,
    input logic              ovr,
    input logic              mask_en,
    input logic              irq_n,
    input logic              tx_slot_stb,
    input logic              tx_bit,
    input logic [DATA_W-1:0] rx_data
);
    assert_done_sets_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |=> full);

    assert_rxdata_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_done |=> $stable(rx_data));

    assert_irq_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_en |-> irq_n);

    assert_irq_needs_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> full);

    assert_overrun_on_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && full) |=> ovr);

    assert_tx_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_slot_stb |=> $stable(tx_bit));
endmodule

bind fdl_byte_port fdl_port_checker #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_done(rx_done), .full(full), .ovr(ovr),
    .mask_en(mask_en), .irq_n(irq_n), .tx_slot_stb(tx_slot_stb),
    .tx_bit(tx_bit), .rx_data(rx_data)
);

// File: tb/test_fdl_byte_port.sv
module test_fdl_byte_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_d4 = 1'b0;
    logic       rx_bit_stb = 1'b0, rx_bit = 1'b0, rx_mf_stb = 1'b0;
    logic       tx_slot_stb = 1'b0;
    logic       tx_bit;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       irq_n;

    int total = 0;
    int fails = 0;

    fdl_byte_port i_fdl_byte_port (
        .clk(clk), .rst_n(rst_n), .mode_d4(mode_d4),
        .rx_bit_stb(rx_bit_stb), .rx_bit(rx_bit), .rx_mf_stb(rx_mf_stb),
        .tx_slot_stb(tx_slot_stb), .tx_bit(tx_bit),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_n(irq_n)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic send_bit(input logic b, input logic mf);
        rx_bit_stb = 1'b1; rx_bit = b; rx_mf_stb = mf;
        tick();
        rx_bit_stb = 1'b0; rx_mf_stb = 1'b0;
    endtask

    task automatic slot();
        tx_slot_stb = 1'b1;
        tick();
        tx_slot_stb = 1'b0;
    endtask

    task automatic chk_reg(input logic [1:0] a, input logic [7:0] exp, input string req);
        logic [7:0] v;
        rd(a, v);
        chk(v == exp, req, v, exp);
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int b = 0; b < 8; b++) send_bit(v[b], 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        total++;
        $display("FAIL watchdog actual=%h expected=%h", 8'h1, 8'h0);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [7:0] prev;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1 reset values
        for (int a = 0; a < 4; a++) chk_reg(2'(a), 8'h00, "R1 reset reg");
        chk(irq_n == 1'b1, "R1 irq_n", {7'd0, irq_n}, 8'h01);
        chk(tx_bit == 1'b0, "R1 tx_bit", {7'd0, tx_bit}, 8'h00);

        // R12 register access
        wr(2'd1, 8'h5A);
        chk_reg(2'd1, 8'h5A, "R12 tx readback");
        wr(2'd0, 8'hAA);
        chk_reg(2'd0, 8'h00, "R12 rx write ignored");
        wr(2'd3, 8'hFB);
        chk_reg(2'd3, 8'h00, "R12 mask other bits");
        wr(2'd3, 8'h00);

        // R2 R3 R7 R8: ESF receive sweep, mf strobe sprinkled in
        prev = 8'h00;
        for (int v = 0; v < 256; v++) begin
            for (int b = 0; b < 7; b++) send_bit(v[b], (v % 2 == 1) && (b == 3));
            chk_reg(2'd0, prev, "R3 rx hold before completion");
            send_bit(v[7], 1'b0);
            chk_reg(2'd0, 8'(v), "R2 R7 R8 esf rx byte");
            chk_reg(2'd2, 8'h04, "R3 full set");
            wr(2'd2, 8'h04);
            chk_reg(2'd2, 8'h00, "R5 full cleared");
            prev = 8'(v);
        end

        // R4 interrupt masking
        send_byte(8'h3C);
        chk(irq_n == 1'b1, "R4 masked irq", {7'd0, irq_n}, 8'h01);
        wr(2'd3, 8'h04);
        chk(irq_n == 1'b0, "R4 irq asserted", {7'd0, irq_n}, 8'h00);
        // R5 write zero no effect
        wr(2'd2, 8'hF3);
        chk_reg(2'd2, 8'h04, "R5 write zero keeps full");
        // R6 R7 overrun and overwrite
        send_byte(8'hFF);
        chk_reg(2'd2, 8'h0C, "R6 overrun set");
        chk_reg(2'd0, 8'hFF, "R7 overwrite unread");
        wr(2'd2, 8'h08);
        chk_reg(2'd2, 8'h04, "R6 overrun cleared");
        wr(2'd2, 8'h04);
        chk(irq_n == 1'b1, "R4 irq released", {7'd0, irq_n}, 8'h01);
        wr(2'd3, 8'h00);

        // R5 set wins over same-cycle clear
        for (int b = 0; b < 7; b++) send_bit(1'b0, 1'b0);
        rx_bit_stb = 1'b1; rx_bit = 1'b1;
        reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = 8'h04;
        tick();
        rx_bit_stb = 1'b0; reg_wr = 1'b0;
        chk_reg(2'd2, 8'h04, "R5 set priority");
        chk_reg(2'd0, 8'h80, "R2 byte with clear");
        wr(2'd2, 8'h04);

        // R8 D4 receive sweep
        mode_d4 = 1'b1;
        prev = 8'h80;
        for (int v = 0; v < 64; v++) begin
            for (int b = 0; b < 5; b++) send_bit(v[b], 1'b0);
            if (v % 2 == 1) begin
                send_bit(v[5], 1'b0);
                send_bit(1'b1, 1'b0);
                send_bit(1'b1, 1'b1);
            end else begin
                chk_reg(2'd0, prev, "R8 d4 hold until multiframe");
                send_bit(v[5], 1'b1);
            end
            chk_reg(2'd0, 8'(v), "R8 d4 rx byte");
            wr(2'd2, 8'h04);
            prev = 8'(v);
        end
        mode_d4 = 1'b0;

        // R9 R11 ESF transmit sweep; shadow still holds 0x5A from R12 write? no: loads at wrap
        wr(2'd1, 8'h00);
        for (int b = 0; b < 8; b++) begin
            chk(tx_bit == 1'b0, "R9 initial zero byte", {7'd0, tx_bit}, 8'h00);
            slot();
        end
        for (int v = 0; v < 256; v++) begin
            wr(2'd1, 8'(v + 1));
            for (int b = 0; b < 8; b++) begin
                chk(tx_bit == 1'((v >> b) & 1), "R9 esf tx bit", {7'd0, tx_bit}, 8'((v >> b) & 1));
                slot();
            end
        end
        // shadow now holds 0x00 (256 truncated); host reg 0x00
        wr(2'd1, 8'hC5);
        for (int b = 0; b < 8; b++) slot();
        for (int r = 0; r < 2; r++)
            for (int b = 0; b < 8; b++) begin
                chk(tx_bit == 1'((8'hC5 >> b) & 1), "R11 repeat byte", {7'd0, tx_bit}, 8'((8'hC5 >> b) & 1));
                slot();
            end

        // R10 D4 transmit sweep, upper bits set but never sent
        mode_d4 = 1'b1;
        wr(2'd1, 8'hC0);
        for (int b = 0; b < 6; b++) slot();
        for (int v = 0; v < 64; v++) begin
            wr(2'd1, 8'((v + 1) | 8'hC0));
            for (int b = 0; b < 6; b++) begin
                chk(tx_bit == 1'((v >> b) & 1), "R10 d4 tx bit", {7'd0, tx_bit}, 8'((v >> b) & 1));
                slot();
            end
        end

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule